// File: doc/BRIEF.md
# Indirect Register Access Sequencer

This block sits on the host side of a management bus. It turns one simple request into the direct bus accesses that a remote device needs. A request is a read or a write, with a device number, a register number and write data. The block drives a single-access bus master port that uses a request/acknowledge handshake, and it reports each request once as a completion carrying an error code and, for reads, the data.

How a request is carried out depends on three configuration inputs, sampled when the request is accepted.

- **Dual-device variant.** The block makes one access at the base address plus the device number.
- **Base address of zero.** The block makes one access at the device number.
- **Non-zero base with shared-bus support.** The block switches to indirect mode. It polls the remote command register until its busy flag drops, then writes a command word (and, for writes, the data register first). Finally it waits again or fetches the result from the data register.
- **Any other combination.** The request is refused as a configuration error.

A poll gives up after a fixed number of busy reads. Any bus error stops the sequence at once.

Top module: `regacc_sequencer`

## Requirements
- R1: With `cfg_dual` high, a request makes exactly one bus access. The access uses address `(cfg_base + req_dev) mod 2^ADDR_W`, register `req_reg`, direction `req_write` and, for writes, data `req_wdata`.
- R2: With `cfg_dual` low and `cfg_base` zero, a request makes exactly one bus access. The access uses address `req_dev`, register `req_reg`, direction `req_write` and, for writes, `req_wdata`.
- R3: Polling behaviour in indirect mode:
  - Every poll is a read of register offset 0 at address `cfg_base`.
  - A poll ends as soon as a read returns bit 15 clear.
  - After POLL_MAX (16) reads that all return bit 15 set, the request completes with error code 1 and makes no further access.
- R4: An indirect read performs, in order:
  1. a poll;
  2. a write to offset 0;
  3. a poll;
  4. a read of offset 1.

  The command word written to offset 0 is laid out as follows:
  - bit 15 = 1;
  - bit 12 = 1;
  - bits 11:10 = 10 for a read, 01 for a write;
  - bits 9:5 = device;
  - bits 4:0 = register;
  - all other bits = 0.
- R5: An indirect write performs, in order:
  1. a poll;
  2. a write of `req_wdata` to offset 1;
  3. a write of the command word to offset 0;
  4. a final poll.
- R6: With `cfg_dual` low, `cfg_base` non-zero and `cfg_shared` low, the request makes no bus access. It completes with error code 3 in the cycle after acceptance.
- R7: A bus acknowledge with `bus_err` high ends the request with error code 2, and no further access follows.
- R8: Request handshake and sampling:
  - `req_ready` is high only while idle.
  - `done` is a one-cycle pulse, during which `req_ready` is low.
  - `req_ready` returns in the cycle after `done`.
  - Configuration and request fields are captured at acceptance, so later changes to them have no effect on that request.
- R9: `done_rdata` carries the final read data of a successful read and is zero on writes and on any error completion.
- R10: Bus port rules:
  - Once `bus_req` rises, it and all access fields stay stable until the cycle in which `bus_ack` is high.
  - `bus_wdata` is zero during reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_base | input | ADDR_W | Base bus address of the remote device |
| cfg_dual | input | 1 | Dual-device direct variant |
| cfg_shared | input | 1 | Shared-bus (indirect) access supported |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dev | input | ADDR_W | Device number |
| req_reg | input | REG_W | Register number |
| req_wdata | input | DATA_W | Write data |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 2 | 0 ok, 1 timeout, 2 bus error, 3 bad configuration |
| done_rdata | output | DATA_W | Read result |
| bus_req | output | 1 | Bus access request |
| bus_write | output | 1 | Access direction |
| bus_addr | output | ADDR_W | Bus device address |
| bus_reg | output | REG_W | Bus register number |
| bus_wdata | output | DATA_W | Bus write data |
| bus_ack | input | 1 | Access finished |
| bus_err | input | 1 | Access failed (valid with `bus_ack`) |
| bus_rdata | input | DATA_W | Read data (valid with `bus_ack`) |

## Verification
The bench builds the block with its default parameters:

- 5-bit addresses and registers;
- 16-bit data;
- a poll limit of 16;
- the busy flag at bit 15.

With these values, both the last allowed poll (15 busy reads, then clear) and the timeout (16 busy reads) take only a few dozen cycles. The 5-bit address also lets the dual variant show wrap-around with a base near the top of the address space.

The bench also varies three things per request:

- the acknowledge latency;
- the number of busy replies in each of the two polls;
- the position of an injected bus error.

Together these reach every abort point in both indirect orderings.

// File: rtl/ras_pkg.sv
package ras_pkg;

   typedef enum logic [1:0] {
      ERR_OK      = 2'd0,
      ERR_TIMEOUT = 2'd1,
      ERR_BUS     = 2'd2,
      ERR_CFG     = 2'd3
   } ras_err_e;

   typedef enum logic [1:0] {
      MODE_DIRECT   = 2'd0,
      MODE_DUAL     = 2'd1,
      MODE_INDIRECT = 2'd2,
      MODE_INVALID  = 2'd3
   } ras_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_DIRECT  = 3'd1,
      ST_POLL_A  = 3'd2,
      ST_DATA_WR = 3'd3,
      ST_CMD_WR  = 3'd4,
      ST_POLL_B  = 3'd5,
      ST_DATA_RD = 3'd6,
      ST_FINISH  = 3'd7
   } ras_state_e;

endpackage

// File: rtl/ras_mode_sel.sv
module ras_mode_sel
   import ras_pkg::*;
#(
   parameter int ADDR_W = 5
) (
   input  logic [ADDR_W-1:0] base,
   input  logic              dual,
   input  logic              shared,
   output ras_mode_e         mode
);

   localparam logic [ADDR_W-1:0] ZERO_ADDR = '0;

   if (ADDR_W < 1) begin : g_bad_addr_w
      $error("ras_mode_sel: ADDR_W must be at least 1");
   end

   // Priority: dual variant, then zero base, then shared support.
   always_comb begin
      if (dual)
         mode = MODE_DUAL;
      else if (base == ZERO_ADDR)
         mode = MODE_DIRECT;
      else if (shared)
         mode = MODE_INDIRECT;
      else
         mode = MODE_INVALID;
   end

endmodule

// File: rtl/ras_cmd_word.sv
module ras_cmd_word #(
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 5,
   parameter int REG_W    = 5,
   parameter int BUSY_BIT = 15,
   parameter int MODE_BIT = 12,
   parameter int OP_LSB   = 10
) (
   input  logic              is_write,
   input  logic [ADDR_W-1:0] dev,
   input  logic [REG_W-1:0]  regn,
   output logic [DATA_W-1:0] word
);

   localparam int FIELD_TOP = REG_W + ADDR_W;
   localparam logic [1:0] OP_RD = 2'b10;
   localparam logic [1:0] OP_WR = 2'b01;

   if (BUSY_BIT >= DATA_W) begin : g_bad_busy
      $error("ras_cmd_word: BUSY_BIT outside data word");
   end
   if (FIELD_TOP > OP_LSB) begin : g_bad_fields
      $error("ras_cmd_word: device and register fields overlap opcode");
   end
   if (OP_LSB + 2 > MODE_BIT || MODE_BIT >= BUSY_BIT) begin : g_bad_order
      $error("ras_cmd_word: opcode, mode and busy bits must ascend");
   end

   always_comb begin
      word                 = '0;
      word[BUSY_BIT]       = 1'b1;
      word[MODE_BIT]       = 1'b1;
      word[OP_LSB +: 2]    = is_write ? OP_WR : OP_RD;
      word[REG_W +: ADDR_W] = dev;
      word[0 +: REG_W]     = regn;
   end

endmodule

// File: rtl/ras_poll_ctr.sv
module ras_poll_ctr #(
   parameter int POLL_MAX = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic step,
   output logic last
);

   localparam int CNT_W = (POLL_MAX > 1) ? $clog2(POLL_MAX) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(POLL_MAX - 1);

   if (POLL_MAX < 2) begin : g_bad_poll
      $error("ras_poll_ctr: POLL_MAX must be at least 2");
   end

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clear)
         cnt <= '0;
      else if (step)
         cnt <= cnt + 1'b1;
   end

   assign last = (cnt == CNT_LAST);

   AST_POLL_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> !last); // R3

endmodule

// File: rtl/ras_fsm.sv
module ras_fsm
   import ras_pkg::*;
#(
   parameter int ADDR_W   = 5,
   parameter int REG_W    = 5,
   parameter int DATA_W   = 16,
   parameter int BUSY_BIT = 15,
   parameter int CMD_OFS  = 0,
   parameter int DATA_OFS = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_dev,
   input  logic [REG_W-1:0]  req_reg,
   input  logic [DATA_W-1:0] req_wdata,
   input  ras_mode_e         mode_in,
   input  logic [ADDR_W-1:0] base_in,
   input  logic [DATA_W-1:0] cmd_word,
   output logic              lat_write,
   output logic [ADDR_W-1:0] lat_dev,
   output logic [REG_W-1:0]  lat_reg,
   output logic              poll_clear,
   output logic              poll_step,
   input  logic              poll_last,
   output logic              bus_req,
   output logic              bus_write,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [REG_W-1:0]  bus_reg,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_ack,
   input  logic              bus_err,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              done,
   output ras_err_e          done_err,
   output logic [DATA_W-1:0] done_rdata
);

   localparam logic [REG_W-1:0] REG_CMD  = REG_W'(CMD_OFS);
   localparam logic [REG_W-1:0] REG_DATA = REG_W'(DATA_OFS);

   if (CMD_OFS == DATA_OFS) begin : g_bad_ofs
      $error("ras_fsm: command and data offsets must differ");
   end
   if (BUSY_BIT >= DATA_W) begin : g_bad_busy
      $error("ras_fsm: BUSY_BIT outside data word");
   end

   ras_state_e        state;
   ras_mode_e         mode_q;
   logic [ADDR_W-1:0] base_q;
   logic              write_q;
   logic [ADDR_W-1:0] dev_q;
   logic [REG_W-1:0]  reg_q;
   logic [DATA_W-1:0] wdata_q;
   ras_err_e          err_q;
   logic [DATA_W-1:0] rdata_q;

   logic in_poll;
   logic busy_seen;
   logic ack_ok;

   assign in_poll   = (state == ST_POLL_A) || (state == ST_POLL_B);
   assign busy_seen = bus_rdata[BUSY_BIT];
   assign ack_ok    = bus_ack && !bus_err;

   assign req_ready  = (state == ST_IDLE);
   assign done       = (state == ST_FINISH);
   assign done_err   = err_q;
   assign done_rdata = rdata_q;

   assign lat_write = write_q;
   assign lat_dev   = dev_q;
   assign lat_reg   = reg_q;

   assign poll_clear = !in_poll;
   assign poll_step  = in_poll && ack_ok && busy_seen && !poll_last;

   // Access fields follow the current step of the sequence.
   always_comb begin
      bus_req   = 1'b0;
      bus_write = 1'b0;
      bus_addr  = base_q;
      bus_reg   = REG_CMD;
      bus_wdata = '0;
      case (state)
         ST_DIRECT: begin
            bus_req   = 1'b1;
            bus_write = write_q;
            bus_addr  = (mode_q == MODE_DUAL) ? base_q + dev_q : dev_q;
            bus_reg   = reg_q;
            bus_wdata = write_q ? wdata_q : '0;
         end
         ST_POLL_A, ST_POLL_B: begin
            bus_req = 1'b1;
         end
         ST_DATA_WR: begin
            bus_req   = 1'b1;
            bus_write = 1'b1;
            bus_reg   = REG_DATA;
            bus_wdata = wdata_q;
         end
         ST_CMD_WR: begin
            bus_req   = 1'b1;
            bus_write = 1'b1;
            bus_wdata = cmd_word;
         end
         ST_DATA_RD: begin
            bus_req = 1'b1;
            bus_reg = REG_DATA;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         mode_q  <= MODE_DIRECT;
         base_q  <= '0;
         write_q <= 1'b0;
         dev_q   <= '0;
         reg_q   <= '0;
         wdata_q <= '0;
         err_q   <= ERR_OK;
         rdata_q <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  mode_q  <= mode_in;
                  base_q  <= base_in;
                  write_q <= req_write;
                  dev_q   <= req_dev;
                  reg_q   <= req_reg;
                  wdata_q <= req_wdata;
                  rdata_q <= '0;
                  err_q   <= ERR_OK;
                  case (mode_in)
                     MODE_DIRECT, MODE_DUAL: state <= ST_DIRECT;
                     MODE_INDIRECT:          state <= ST_POLL_A;
                     default: begin
                        err_q <= ERR_CFG;
                        state <= ST_FINISH;
                     end
                  endcase
               end
            end
            ST_FINISH: state <= ST_IDLE;
            default: begin
               if (bus_ack && bus_err) begin
                  err_q <= ERR_BUS;
                  state <= ST_FINISH;
               end else if (bus_ack) begin
                  case (state)
                     ST_DIRECT: begin
                        if (!write_q)
                           rdata_q <= bus_rdata;
                        state <= ST_FINISH;
                     end
                     ST_POLL_A, ST_POLL_B: begin
                        if (busy_seen) begin
                           if (poll_last) begin
                              err_q <= ERR_TIMEOUT;
                              state <= ST_FINISH;
                           end
                        end else if (state == ST_POLL_A) begin
                           state <= write_q ? ST_DATA_WR : ST_CMD_WR;
                        end else begin
                           state <= write_q ? ST_FINISH : ST_DATA_RD;
                        end
                     end
                     ST_DATA_WR: state <= ST_CMD_WR;
                     ST_CMD_WR:  state <= ST_POLL_B;
                     ST_DATA_RD: begin
                        rdata_q <= bus_rdata;
                        state   <= ST_FINISH;
                     end
                     default: state <= ST_IDLE;
                  endcase
               end
            end
         endcase
      end
   end

   AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_reg)
                                 && $stable(bus_write) && $stable(bus_wdata))); // R10

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && req_ready)); // R8

   AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_err != ERR_OK) |-> (done_rdata == '0)); // R9

   AST_RD_NO_WDATA: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_write) |-> (bus_wdata == '0)); // R10

endmodule

// File: rtl/regacc_sequencer.sv
module regacc_sequencer
   import ras_pkg::*;
#(
   parameter int ADDR_W   = 5,
   parameter int REG_W    = 5,
   parameter int DATA_W   = 16,
   parameter int POLL_MAX = 16,
   parameter int BUSY_BIT = 15,
   parameter int MODE_BIT = 12,
   parameter int OP_LSB   = 10,
   parameter int CMD_OFS  = 0,
   parameter int DATA_OFS = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic              cfg_dual,
   input  logic              cfg_shared,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_dev,
   input  logic [REG_W-1:0]  req_reg,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              done,
   output logic [1:0]        done_err,
   output logic [DATA_W-1:0] done_rdata,
   output logic              bus_req,
   output logic              bus_write,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [REG_W-1:0]  bus_reg,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_ack,
   input  logic              bus_err,
   input  logic [DATA_W-1:0] bus_rdata
);

   if (DATA_OFS >= (1 << REG_W) || CMD_OFS >= (1 << REG_W)) begin : g_bad_ofs
      $error("regacc_sequencer: register offsets exceed REG_W");
   end

   ras_mode_e         mode;
   ras_err_e          err_e;
   logic [DATA_W-1:0] cmd_word;
   logic              lat_write;
   logic [ADDR_W-1:0] lat_dev;
   logic [REG_W-1:0]  lat_reg;
   logic              poll_clear;
   logic              poll_step;
   logic              poll_last;

   ras_mode_sel #(.ADDR_W(ADDR_W)) u_mode (
      .base   (cfg_base),
      .dual   (cfg_dual),
      .shared (cfg_shared),
      .mode   (mode)
   );

   ras_cmd_word #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_W(REG_W),
      .BUSY_BIT(BUSY_BIT), .MODE_BIT(MODE_BIT), .OP_LSB(OP_LSB)
   ) u_cmd (
      .is_write (lat_write),
      .dev      (lat_dev),
      .regn     (lat_reg),
      .word     (cmd_word)
   );

   ras_poll_ctr #(.POLL_MAX(POLL_MAX)) u_poll (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (poll_clear),
      .step  (poll_step),
      .last  (poll_last)
   );

   ras_fsm #(
      .ADDR_W(ADDR_W), .REG_W(REG_W), .DATA_W(DATA_W),
      .BUSY_BIT(BUSY_BIT), .CMD_OFS(CMD_OFS), .DATA_OFS(DATA_OFS)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_write  (req_write),
      .req_dev    (req_dev),
      .req_reg    (req_reg),
      .req_wdata  (req_wdata),
      .mode_in    (mode),
      .base_in    (cfg_base),
      .cmd_word   (cmd_word),
      .lat_write  (lat_write),
      .lat_dev    (lat_dev),
      .lat_reg    (lat_reg),
      .poll_clear (poll_clear),
      .poll_step  (poll_step),
      .poll_last  (poll_last),
      .bus_req    (bus_req),
      .bus_write  (bus_write),
      .bus_addr   (bus_addr),
      .bus_reg    (bus_reg),
      .bus_wdata  (bus_wdata),
      .bus_ack    (bus_ack),
      .bus_err    (bus_err),
      .bus_rdata  (bus_rdata),
      .done       (done),
      .done_err   (err_e),
      .done_rdata (done_rdata)
   );

   assign done_err = err_e;

   AST_CFG_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && mode == MODE_INVALID) |=> (done && done_err == 2'd3)); // R6

endmodule

// File: tb/regacc_sequencer_tb.sv
`timescale 1ns/1ps
module regacc_sequencer_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  cfg_base = '0;
   logic        cfg_dual = 1'b0;
   logic        cfg_shared = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [4:0]  req_dev = '0;
   logic [4:0]  req_reg = '0;
   logic [15:0] req_wdata = '0;
   logic        done;
   logic [1:0]  done_err;
   logic [15:0] done_rdata;
   logic        bus_req;
   logic        bus_write;
   logic [4:0]  bus_addr;
   logic [4:0]  bus_reg;
   logic [15:0] bus_wdata;
   logic        bus_ack = 1'b0;
   logic        bus_err = 1'b0;
   logic [15:0] bus_rdata = '0;

   always #4 clk = ~clk;

   regacc_sequencer u_dut (.*);

   int compared = 0;
   int mismatched = 0;
   int cyc = 0;

   // reference model state
   logic [26:0] exp_q[$];
   int          n_txn;
   int          cur_err_at;
   int          exp_err;
   logic [15:0] exp_rdata;
   string       cur_tag;

   // responder state
   int          lat = 0;
   int          wait_cnt = 0;
   bit          seen = 0;
   logic [26:0] first_txn;
   int          txn_idx = 0;
   int          busy_left = 0;
   int          busy_second = 0;
   bit          resp_indirect = 0;
   logic [15:0] rd_val = '0;

   task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] expv);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
      end
   endtask

   function automatic bit add_txn(logic [26:0] t);
      exp_q.push_back(t);
      n_txn++;
      return (n_txn - 1 == cur_err_at);
   endfunction

   function automatic int poll_model(logic [4:0] base, int b);
      for (int i = 0; i < 16; i++) begin
         if (add_txn({1'b0, base, 5'd0, 16'h0})) return 2;
         if (i >= b) return 0;
      end
      return 1;
   endfunction

   function automatic logic [15:0] cmd_of(bit w, logic [4:0] dev, logic [4:0] rg);
      return 16'h9000 | (w ? 16'h0400 : 16'h0800) | {6'd0, dev, rg};
   endfunction

   // Builds expected transactions and result; returns 1 if indirect.
   function automatic bit build_expect(bit w, logic [4:0] dev, logic [4:0] rg, logic [15:0] wd,
                                       logic [4:0] base, bit dual, bit shared,
                                       int b1, int b2, logic [15:0] rdv);
      int p;
      exp_q.delete();
      n_txn = 0;
      exp_rdata = '0;
      exp_err = 0;
      if (dual || base == 5'd0) begin
         logic [4:0] a;
         a = dual ? base + dev : dev;
         if (add_txn({w, a, rg, w ? wd : 16'h0})) begin exp_err = 2; return 0; end
         if (!w) exp_rdata = rdv;
         return 0;
      end
      if (!shared) begin exp_err = 3; return 0; end
      p = poll_model(base, b1);
      if (p != 0) begin exp_err = p; return 1; end
      if (w) begin
         if (add_txn({1'b1, base, 5'd1, wd})) begin exp_err = 2; return 1; end
      end
      if (add_txn({1'b1, base, 5'd0, cmd_of(w, dev, rg)})) begin exp_err = 2; return 1; end
      p = poll_model(base, b2);
      if (p != 0) begin exp_err = p; return 1; end
      if (!w) begin
         if (add_txn({1'b0, base, 5'd1, 16'h0})) begin exp_err = 2; return 1; end
         exp_rdata = rdv;
      end
      return 1;
   endfunction

   // Bus responder, acting away from the active edge.
   always @(negedge clk) begin
      if (bus_ack) begin
         bus_ack  = 1'b0;
         bus_err  = 1'b0;
         wait_cnt = 0;
         seen     = 0;
      end else if (bus_req) begin
         logic [26:0] t;
         t = {bus_write, bus_addr, bus_reg, bus_wdata};
         if (!seen) begin first_txn = t; seen = 1; end
         if (wait_cnt >= lat) begin
            chk(t == first_txn, "R10", "fields held until ack", {5'd0, t}, {5'd0, first_txn});
            if (exp_q.size() == 0)
               chk(0, cur_tag, "unexpected bus access", {5'd0, t}, 32'h0);
            else begin
               logic [26:0] e;
               e = exp_q.pop_front();
               chk(t == e, cur_tag, "bus access", {5'd0, t}, {5'd0, e});
            end
            bus_rdata = rd_val;
            if (!bus_write && resp_indirect && bus_reg == 5'd0) begin
               if (busy_left > 0) begin bus_rdata = 16'h8123; busy_left--; end
               else bus_rdata = 16'h0055;
            end
            if (bus_write && resp_indirect && bus_reg == 5'd0) busy_left = busy_second;
            bus_err = (txn_idx == cur_err_at);
            if (bus_err) bus_rdata = 16'hDEAD;
            txn_idx++;
            bus_ack = 1'b1;
         end else
            wait_cnt++;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         mismatched++;
         $display("FAIL R8 watchdog: cycles %0d expected below %0d", cyc, 100000);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   task automatic do_req(string tag, bit w, logic [4:0] dev, logic [4:0] rg, logic [15:0] wd,
                         logic [4:0] base, bit dual, bit shared, int b1, int b2,
                         int err_at, logic [15:0] rdv, int latency, bit flip);
      int cycles;
      cur_tag    = tag;
      cur_err_at = err_at;
      resp_indirect = build_expect(w, dev, rg, wd, base, dual, shared, b1, b2, rdv);
      busy_left   = b1;
      busy_second = b2;
      rd_val      = rdv;
      lat         = latency;
      txn_idx     = 0;
      @(negedge clk);
      cfg_base = base; cfg_dual = dual; cfg_shared = shared;
      req_write = w; req_dev = dev; req_reg = rg; req_wdata = wd;
      req_valid = 1'b1;
      chk(req_ready == 1'b1, "R8", "ready while idle", {31'd0, req_ready}, 32'd1);
      @(negedge clk);
      req_valid = 1'b0;
      if (flip) begin
         cfg_base = base ^ 5'h1F; cfg_dual = ~dual; cfg_shared = ~shared;
         req_write = ~w; req_dev = ~dev; req_reg = ~rg; req_wdata = ~wd;
      end
      cycles = 1;
      while (!done) begin
         @(negedge clk);
         cycles++;
      end
      chk(done_err == 2'(exp_err), tag, "completion code", {30'd0, done_err}, exp_err);
      chk(done_rdata == exp_rdata, "R9", "completion data", {16'd0, done_rdata}, {16'd0, exp_rdata});
      chk(exp_q.size() == 0, tag, "missing bus accesses", exp_q.size(), 32'd0);
      chk(req_ready == 1'b0, "R8", "not ready during done", {31'd0, req_ready}, 32'd0);
      if (exp_err == 3)
         chk(cycles == 1, "R6", "reject latency", cycles, 32'd1);
      @(negedge clk);
      chk(done == 1'b0 && req_ready == 1'b1, "R8", "done one cycle then ready",
          {30'd0, done, req_ready}, 32'd1);
   endtask

   initial begin
      n_txn = 0;
      cur_err_at = -1;
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b1 && bus_req == 1'b0 && done == 1'b0, "R8", "reset state",
          {29'd0, req_ready, bus_req, done}, 32'b100);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 plain direct
      do_req("R2", 0, 5'd3, 5'd7, 16'h0, 5'd0, 0, 0, 0, 0, -1, 16'hA5C3, 0, 0);
      do_req("R2", 1, 5'd9, 5'd2, 16'h1234, 5'd0, 0, 1, 0, 0, -1, 16'h0, 2, 0);
      // R1 dual with wrap
      do_req("R1", 0, 5'd5, 5'd11, 16'h0, 5'd30, 1, 0, 0, 0, -1, 16'h7E01, 1, 0);
      do_req("R1", 1, 5'd1, 5'd31, 16'hBEEF, 5'd16, 1, 1, 0, 0, -1, 16'h0, 0, 0);
      // R4 indirect reads
      do_req("R4", 0, 5'd4, 5'd1, 16'h0, 5'd2, 0, 1, 0, 0, -1, 16'h4321, 0, 0);
      do_req("R4", 0, 5'd31, 5'd19, 16'h0, 5'd6, 0, 1, 3, 5, -1, 16'hFFFF, 1, 0);
      // R5 indirect writes
      do_req("R5", 1, 5'd12, 5'd26, 16'hC0DE, 5'd2, 0, 1, 2, 1, -1, 16'h0, 2, 0);
      do_req("R5", 1, 5'd0, 5'd0, 16'h0001, 5'd8, 0, 1, 0, 0, -1, 16'h0, 0, 0);
      // R3 last allowed poll and timeouts
      do_req("R3", 0, 5'd7, 5'd3, 16'h0, 5'd4, 0, 1, 15, 0, -1, 16'h1357, 0, 0);
      do_req("R3", 0, 5'd7, 5'd3, 16'h0, 5'd4, 0, 1, 16, 0, -1, 16'h1357, 0, 0);
      do_req("R3", 1, 5'd2, 5'd9, 16'h5A5A, 5'd4, 0, 1, 0, 16, -1, 16'h0, 1, 0);
      // R6 invalid configuration
      do_req("R6", 0, 5'd1, 5'd1, 16'h0, 5'd4, 0, 0, 0, 0, -1, 16'h0, 0, 0);
      // R7 bus errors at several points
      do_req("R7", 0, 5'd6, 5'd6, 16'h0, 5'd0, 0, 0, 0, 0, 0, 16'h9999, 1, 0);
      do_req("R7", 1, 5'd6, 5'd6, 16'hAAAA, 5'd10, 0, 1, 0, 0, 2, 16'h0, 0, 0);
      do_req("R7", 0, 5'd6, 5'd6, 16'h0, 5'd10, 0, 1, 0, 0, 3, 16'h2468, 0, 0);
      do_req("R7", 0, 5'd6, 5'd6, 16'h0, 5'd10, 0, 1, 4, 0, 2, 16'h2468, 0, 0);
      // R8 request and configuration sampled at acceptance
      do_req("R8", 0, 5'd13, 5'd21, 16'h0, 5'd14, 0, 1, 1, 2, -1, 16'h0F0F, 1, 1);
      do_req("R8", 1, 5'd3, 5'd4, 16'h6006, 5'd0, 0, 0, 0, 0, -1, 16'h0, 0, 1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule